// File: doc/BRIEF.md
# Write Unlock Sequence Detector

This block stands between the bus decoder of a nonvolatile byte-wide memory and its page write controller. It watches every decoded write (one-cycle strobe with address and data) and lets a data write through only after a fixed three-write command sequence. The writes must arrive in this order: key 0xAA to address 0x5555, key 0x55 to address 0x2AAA, then key 0xA0 to address 0x5555. Each write must follow the one before it within a byte-load window. The window length is a cycle count derived from the clock frequency and a time in microseconds (100 µs by default).

Once the third command is seen, a write window opens. Each write inside it is forwarded to the page write controller one cycle later. When no further write arrives within the window, the window closes and, if at least one data byte was loaded, a one-cycle commit pulse tells the controller to start programming. Protection is then armed again, so every burst needs a fresh sequence. The command writes themselves never reach the controller. While the controller reports a programming cycle in progress, all writes are ignored.

Top module: `wr_unlock_guard`

## Requirements
- R1: After reset `unlocked`, `fwd_valid` and `burst_commit` are all 0.
- R2: The writes 0xAA to 0x5555, 0x55 to 0x2AAA and 0xA0 to 0x5555, in that order, open the window: `unlocked` is 1 in the cycle after the third write is sampled.
- R3: During the sequence, a write with the wrong address or the wrong data returns the detector to idle, and the remaining correct steps do not open the window.
- R4: With WINDOW_CYC = CLK_KHZ*WINDOW_US/1000, a step sampled WINDOW_CYC cycles after the previous accepted write is accepted. A step sampled later finds the detector idle and does not open the window.
- R5: Command writes of the sequence are never forwarded: `fwd_valid` stays 0 after each of them.
- R6: Every write sampled while the window is open raises `fwd_valid` for one cycle in the next cycle, with `fwd_addr` and `fwd_data` equal to the written address and data.
- R7: A write not preceded by a complete sequence is not forwarded.
- R8: The window closes WINDOW_CYC cycles after its last accepted write. If at least one data write was forwarded, `burst_commit` is 1 for exactly one cycle, in the same cycle that `unlocked` falls.
- R9: A window that expires with no data write closes without a `burst_commit` pulse.
- R10: While `prog_busy` is 1, writes are ignored and `unlocked` is 0 from the next cycle on.
- R11: After a commit the block is locked again: a following data write is not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_valid | input | 1 | One-cycle strobe for a decoded write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| prog_busy | input | 1 | Programming cycle in progress |
| unlocked | output | 1 | Write window is open |
| fwd_valid | output | 1 | Forwarded data write strobe |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_data | output | DATA_W | Forwarded data |
| burst_commit | output | 1 | One-cycle pulse: start programming |

## Verification
The bench builds the block with CLK_KHZ = 1000 and WINDOW_US = 16, so the window is 16 cycles and not thousands. At that size each window edge can be reached directly: a step exactly at the limit and one a cycle past it, and the expiry cycle with its commit pulse. Address and data widths keep their defaults, so the real key addresses and values are exercised. Random trials mix correct sequences with ones broken by a wrong address, wrong data or a late step.

// File: rtl/wul_pkg.sv
package wul_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM1 = 2'd1,
      ST_ARM2 = 2'd2,
      ST_OPEN = 2'd3
   } wul_state_e;

endpackage

// File: rtl/wul_timer.sv
module wul_timer #(
   parameter int unsigned WINDOW_CYC = 25000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic expired
);
   localparam int unsigned CW = $clog2(WINDOW_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(WINDOW_CYC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || restart)
         cnt <= '0;
      else if (cnt != LAST)
         cnt <= cnt + 1'b1;
   end

   assign expired = run && !restart && (cnt == LAST);
endmodule

// File: rtl/wul_seq_fsm.sv
module wul_seq_fsm
   import wul_pkg::*;
#(
   parameter int unsigned ADDR_W     = 15,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned CMD_ADDR_A = 'h5555,
   parameter int unsigned CMD_ADDR_B = 'h2AAA,
   parameter int unsigned KEY1       = 'hAA,
   parameter int unsigned KEY2       = 'h55,
   parameter int unsigned KEY3       = 'hA0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              prog_busy,
   input  logic              expired,
   output logic              armed,
   output logic              unlocked,
   output logic              take,
   output logic              commit_q
);
   wul_state_e st, nxt;
   logic       have_data;
   logic       fire_commit;
   logic       hit1, hit2, hit3;

   assign hit1 = (wr_addr == ADDR_W'(CMD_ADDR_A)) && (wr_data == DATA_W'(KEY1));
   assign hit2 = (wr_addr == ADDR_W'(CMD_ADDR_B)) && (wr_data == DATA_W'(KEY2));
   assign hit3 = (wr_addr == ADDR_W'(CMD_ADDR_A)) && (wr_data == DATA_W'(KEY3));

   always_comb begin
      nxt         = st;
      take        = 1'b0;
      fire_commit = 1'b0;
      if (prog_busy) begin
         nxt = ST_IDLE;
      end else begin
         case (st)
            ST_IDLE: if (wr_valid && hit1) nxt = ST_ARM1;
            ST_ARM1: begin
               if (wr_valid)     nxt = hit2 ? ST_ARM2 : ST_IDLE;
               else if (expired) nxt = ST_IDLE;
            end
            ST_ARM2: begin
               if (wr_valid)     nxt = hit3 ? ST_OPEN : ST_IDLE;
               else if (expired) nxt = ST_IDLE;
            end
            ST_OPEN: begin
               if (wr_valid) begin
                  take = 1'b1;
               end else if (expired) begin
                  nxt         = ST_IDLE;
                  fire_commit = have_data;
               end
            end
            default: nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         have_data <= 1'b0;
         commit_q  <= 1'b0;
      end else begin
         st        <= nxt;
         have_data <= (nxt == ST_OPEN) && (have_data || take);
         commit_q  <= fire_commit;
      end
   end

   assign armed    = (st != ST_IDLE);
   assign unlocked = (st == ST_OPEN);
endmodule

// File: rtl/wul_fwd_reg.sv
module wul_fwd_reg #(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= take;
         if (take) begin
            out_addr <= in_addr;
            out_data <= in_data;
         end
      end
   end
endmodule

// File: rtl/wr_unlock_guard.sv
module wr_unlock_guard #(
   parameter int unsigned ADDR_W     = 15,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned CLK_KHZ    = 250000,
   parameter int unsigned WINDOW_US  = 100,
   parameter int unsigned CMD_ADDR_A = 'h5555,
   parameter int unsigned CMD_ADDR_B = 'h2AAA,
   parameter int unsigned KEY1       = 'hAA,
   parameter int unsigned KEY2       = 'h55,
   parameter int unsigned KEY3       = 'hA0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              prog_busy,
   output logic              unlocked,
   output logic              fwd_valid,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic [DATA_W-1:0] fwd_data,
   output logic              burst_commit
);
   localparam int unsigned WINDOW_CYC = (CLK_KHZ * WINDOW_US) / 1000;

   generate
      if (WINDOW_CYC < 2) begin : g_bad_window
         $error("wr_unlock_guard: window must be at least 2 cycles");
      end
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr_w
         $error("wr_unlock_guard: ADDR_W out of range");
      end
      if (DATA_W < 2 || DATA_W > 32) begin : g_bad_data_w
         $error("wr_unlock_guard: DATA_W out of range");
      end
      if (CMD_ADDR_A == CMD_ADDR_B) begin : g_bad_cmd_addr
         $error("wr_unlock_guard: the two command addresses must differ");
      end
      if (KEY1 == KEY3) begin : g_bad_keys
         $error("wr_unlock_guard: first and third keys must differ");
      end
   endgenerate

   logic armed, expired, take, restart;

   assign restart = wr_valid && !prog_busy;

   wul_timer #(.WINDOW_CYC(WINDOW_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (armed),
      .restart (restart),
      .expired (expired)
   );

   wul_seq_fsm #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .CMD_ADDR_A(CMD_ADDR_A), .CMD_ADDR_B(CMD_ADDR_B),
      .KEY1(KEY1), .KEY2(KEY2), .KEY3(KEY3)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (wr_valid),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .prog_busy (prog_busy),
      .expired   (expired),
      .armed     (armed),
      .unlocked  (unlocked),
      .take      (take),
      .commit_q  (burst_commit)
   );

   wul_fwd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .in_addr   (wr_addr),
      .in_data   (wr_data),
      .out_valid (fwd_valid),
      .out_addr  (fwd_addr),
      .out_data  (fwd_data)
   );
endmodule

// File: rtl/wr_unlock_guard_chk.sv
module wr_unlock_guard_chk #(
   parameter int unsigned ADDR_W     = 15,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned CMD_ADDR_A = 'h5555,
   parameter int unsigned KEY3       = 'hA0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              prog_busy,
   input logic              unlocked,
   input logic              fwd_valid,
   input logic [ADDR_W-1:0] fwd_addr,
   input logic [DATA_W-1:0] fwd_data,
   input logic              burst_commit
);
   a_r7_fwd_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> $past(unlocked && wr_valid && !prog_busy));

   a_r6_fwd_payload: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> (fwd_addr == $past(wr_addr)) && (fwd_data == $past(wr_data)));

   a_r2_open_on_third_key: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(wr_valid && wr_addr == ADDR_W'(CMD_ADDR_A)
                                && wr_data == DATA_W'(KEY3)));

   a_r8_commit_closes: assert property (@(posedge clk) disable iff (!rst_n)
      burst_commit |-> !unlocked && $past(unlocked));

   a_r8_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
      burst_commit |=> !burst_commit);

   a_r10_busy_locks: assert property (@(posedge clk) disable iff (!rst_n)
      prog_busy |=> !unlocked && !burst_commit);
endmodule

bind wr_unlock_guard wr_unlock_guard_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR_A(CMD_ADDR_A), .KEY3(KEY3)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
   .wr_data(wr_data), .prog_busy(prog_busy), .unlocked(unlocked),
   .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
   .burst_commit(burst_commit)
);

// File: tb/wr_unlock_guard_test.sv
`timescale 1ns/1ps
module wr_unlock_guard_test;
   localparam int W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [14:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        prog_busy = 1'b0;
   logic        unlocked, fwd_valid, burst_commit;
   logic [14:0] fwd_addr;
   logic [7:0]  fwd_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   wr_unlock_guard #(.CLK_KHZ(1000), .WINDOW_US(16)) uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .prog_busy(prog_busy), .unlocked(unlocked),
      .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
      .burst_commit(burst_commit)
   );

   function automatic logic [14:0] step_addr(int i);
      return (i == 1) ? 15'h2AAA : 15'h5555;
   endfunction

   function automatic logic [7:0] step_data(int i);
      return (i == 0) ? 8'hAA : (i == 1) ? 8'h55 : 8'hA0;
   endfunction

   function automatic bit exp_open(int kind);
      return kind == 0;
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [14:0] a, logic [7:0] d);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_cmd(int i);
      wr(step_addr(i), step_data(i));
      chk(fwd_valid == 1'b0, "R5 command not forwarded", fwd_valid, 0);
   endtask

   initial begin
      repeat (W * 12000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      idle(3);
      chk(!unlocked && !fwd_valid && !burst_commit, "R1 reset state",
          {unlocked, fwd_valid, burst_commit}, 0);
      rst_n = 1'b1;
      idle(2);

      // R7: plain data write with no sequence
      wr(15'h0123, 8'h5A);
      chk(fwd_valid == 1'b0, "R7 unguarded write dropped", fwd_valid, 0);
      idle(W + 2);

      // R4 boundary: steps exactly W cycles apart are accepted
      send_cmd(0); idle(W - 1);
      send_cmd(1); idle(W - 1);
      send_cmd(2);
      chk(unlocked == 1'b1, "R4 step at window limit accepted", unlocked, 1);
      // R9: window expires with no data, no commit
      begin
         int seen = 0;
         for (int i = 0; i < W + 1; i++) begin
            @(negedge clk);
            if (burst_commit) seen++;
         end
         chk(seen == 0, "R9 no commit without data", seen, 0);
         chk(unlocked == 1'b0, "R9 window closed", unlocked, 0);
      end
      idle(2);

      // R4: one cycle past the limit
      send_cmd(0); idle(W);
      send_cmd(1);
      send_cmd(2);
      chk(unlocked == 1'b0, "R4 late step rejected", unlocked, 0);
      idle(W + 2);

      // R10: busy blocks everything
      prog_busy = 1'b1;
      send_cmd(0); send_cmd(1); send_cmd(2);
      chk(unlocked == 1'b0, "R10 busy keeps locked", unlocked, 0);
      wr(15'h0042, 8'h11);
      chk(fwd_valid == 1'b0, "R10 busy write dropped", fwd_valid, 0);
      prog_busy = 1'b0;
      idle(W + 2);

      // Random trials
      for (int t = 0; t < 40; t++) begin
         int kind = $urandom_range(0, 3);
         int s = (kind == 3) ? $urandom_range(1, 2) : $urandom_range(0, 2);
         bit ex = exp_open(kind);
         int n = $urandom_range(1, 4);
         for (int i = 0; i < 3; i++) begin
            logic [14:0] a = step_addr(i);
            logic [7:0]  d = step_data(i);
            int gap = $urandom_range(0, W - 1);
            if (kind == 3 && i == s) gap = W + $urandom_range(0, 3);
            if (i > 0) idle(gap);
            if (kind == 1 && i == s) a = a ^ 15'h0100;
            if (kind == 2 && i == s) d = d ^ 8'h01;
            wr(a, d);
            chk(fwd_valid == 1'b0, "R5 command not forwarded", fwd_valid, 0);
         end
         if (kind == 0)      chk(unlocked == 1'b1, "R2 sequence opens window", unlocked, 1);
         else if (kind == 3) chk(unlocked == 1'b0, "R4 late step resets", unlocked, 0);
         else                chk(unlocked == 1'b0, "R3 wrong step resets", unlocked, 0);
         for (int j = 0; j < n; j++) begin
            logic [14:0] a = 15'($urandom()) & 15'h0FFF;
            logic [7:0]  d = 8'($urandom());
            idle($urandom_range(0, W - 1));
            wr(a, d);
            if (ex) begin
               chk(fwd_valid == 1'b1, "R6 data forwarded", fwd_valid, 1);
               chk(fwd_addr == a && fwd_data == d, "R6 payload",
                   {fwd_addr, fwd_data}, {a, d});
            end else begin
               chk(fwd_valid == 1'b0, "R7 locked write dropped", fwd_valid, 0);
            end
         end
         if (ex) begin
            idle(W - 1);
            chk(unlocked == 1'b1 && burst_commit == 1'b0, "R8 still open before limit",
                {unlocked, burst_commit}, 2'b10);
            idle(1);
            chk(unlocked == 1'b0 && burst_commit == 1'b1, "R8 commit at close",
                {unlocked, burst_commit}, 2'b01);
            idle(1);
            chk(burst_commit == 1'b0, "R8 commit one cycle", burst_commit, 0);
            wr(15'($urandom()) & 15'h0FFF, 8'($urandom()));
            chk(fwd_valid == 1'b0, "R11 relocked after commit", fwd_valid, 0);
            idle(2);
         end else begin
            idle(W + 2);
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule